// File: doc/BRIEF.md
# Disk Sector Read Stream Generator

This block turns one sector of stored 16-bit words into the pulse stream that an emulated cartridge disk drive presents on its read line. When the end of the sector mark is signalled, it first sends a run of all-zero cells. It then sends a synchronisation word, followed by a fixed number of data words fetched one at a time from a word RAM. Each word takes twenty cells on the line: sixteen data bits and four generated check bits. The check bits are chosen so that the count of ones in every twenty-cell group is a multiple of four.

Each cell lasts a parameterised number of system-clock cycles and has two halves. The first half always carries a clock pulse. The second half carries a data pulse only when the cell's bit is a one. The word RAM is read by index with one cycle of read latency. The next word is captured a full cell before its first bit is due, so the RAM timing never touches the cell grid. A busy flag frames the whole sector.

Top module: `rd_stream_gen`

## Requirements
- R1: After an accepted start, the block sends ceil(PRE_CYC / CELL_CYC) preamble cells, all with data value 0.
- R2: Directly after the preamble come 20 sync cells: fifteen 0 cells, then 1, 1, 1, 1, 0.
- R3: Each data word takes 20 cells. Cells 0 to 15 carry rd_data_i bit 0 through bit 15, in that order, so port bit 0 goes first.
- R4: Cells 16 to 19 of each word are check cells. They hold n ones followed by 4-n zeros, where n (0 to 3) is the smallest count that makes the total ones in the 20 cells a multiple of four. As a result, cell 19 is always 0.
- R5: rd_addr_o is 0 while idle, during the preamble and during the sync word. While data word w (counted from 0) is being sent, rd_addr_o is w+1. The RAM returns the word for an address on the clock edge after that address is presented.
- R6: Every cell lasts CELL_CYC cycles. During the first CELL_CYC/2 cycles of a cell, clk_pulse_o is high and data_pulse_o is low. During the remaining cycles, clk_pulse_o is low and data_pulse_o equals the cell's bit.
- R7: busy_o rises on the edge that samples start_i high while idle. It falls on the edge that ends the last cell of word N_WORDS-1.
- R8: start_i has no effect while busy_o is high. The stream in progress goes on unchanged.
- R9: While busy_o is low, clk_pulse_o and data_pulse_o stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | End of sector mark; starts a sector when idle |
| rd_addr_o | output | ADDR_W | Word RAM read index |
| rd_data_i | input | 16 | Word RAM read data, one cycle after the address |
| clk_pulse_o | output | 1 | Clock pulse, first half of each cell |
| data_pulse_o | output | 1 | Data pulse, second half of a cell holding a 1 |
| busy_o | output | 1 | High for the whole sector |

## Verification
The hardest case to reach is a start pulse arriving in the middle of a sector. The block must ignore it, and only the unchanged cell stream shows this. The bench therefore raises start_i partway through a data word of a full-length sector, then compares every following cell against the expected stream.

A second hard-to-reach case is check-bit generation, which has four branches (0 to 3 ones needed). A word-index-driven RAM pattern cycles through data words holding 0, 1, 2 and 3 ones, so every branch recurs across the sector. An all-ones pattern covers the case where 16 ones already divide by four.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int DATA_BITS = 16;
  localparam int CHK_BITS  = 4;
  localparam int WORD_CELLS = DATA_BITS + CHK_BITS;
  localparam int IDX_W = $clog2(WORD_CELLS);
  localparam logic [DATA_BITS-1:0] SYNC_WORD = 16'h8000;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_SYNC,
    ST_DATA
  } rsg_state_e;
endpackage

// File: rtl/rsg_cell_timer.sv
module rsg_cell_timer #(
  parameter int CELL_CYC = 139
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic phase_a_o,
  output logic cell_end_o
);
  localparam int CW   = (CELL_CYC > 2) ? $clog2(CELL_CYC) : 1;
  localparam int HALF = CELL_CYC / 2;

  logic [CW-1:0] cyc_q;

  assign cell_end_o = run_i && (cyc_q == CW'(CELL_CYC - 1));
  assign phase_a_o  = (cyc_q < CW'(HALF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (restart_i) begin
      cyc_q <= '0;
    end else if (run_i) begin
      if (cell_end_o) cyc_q <= '0;
      else            cyc_q <= cyc_q + 1'b1;
    end
  end
endmodule

// File: rtl/rsg_check_enc.sv
module rsg_check_enc
  import rsg_pkg::*;
(
  input  logic [DATA_BITS-1:0]  data_i,
  output logic [WORD_CELLS-1:0] cells_o
);
  logic [$clog2(DATA_BITS+1)-1:0] ones;
  logic [1:0]                     need;

  always_comb begin
    ones = '0;
    for (int i = 0; i < DATA_BITS; i++) ones = ones + $bits(ones)'(data_i[i]);
  end

  // ones needed to reach the next multiple of four
  assign need = 2'd0 - ones[1:0];

  assign cells_o[DATA_BITS-1:0] = data_i;

  for (genvar j = 0; j < CHK_BITS; j++) begin : g_chk
    assign cells_o[DATA_BITS+j] = (need > 2'(j));
  end
endmodule

// File: rtl/rsg_serializer.sv
module rsg_serializer
  import rsg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  load_i,
  input  logic                  shift_i,
  input  logic [WORD_CELLS-1:0] cells_i,
  output logic                  bit_o,
  output logic                  fetch_cell_o,
  output logic                  last_cell_o
);
  logic [WORD_CELLS-1:0] sr_q;
  logic [IDX_W-1:0]      idx_q;

  assign bit_o        = sr_q[0];
  assign fetch_cell_o = (idx_q == IDX_W'(WORD_CELLS - 2));
  assign last_cell_o  = (idx_q == IDX_W'(WORD_CELLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= cells_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {1'b0, sr_q[WORD_CELLS-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/rd_stream_gen.sv
module rd_stream_gen
  import rsg_pkg::*;
#(
  parameter int CELL_CYC = 139,
  parameter int PRE_CYC  = 25000,
  parameter int N_WORDS  = 321,
  parameter int ADDR_W   = $clog2(N_WORDS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic [ADDR_W-1:0]    rd_addr_o,
  input  logic [DATA_BITS-1:0] rd_data_i,
  output logic                 clk_pulse_o,
  output logic                 data_pulse_o,
  output logic                 busy_o
);
  localparam int PRE_CELLS = (PRE_CYC + CELL_CYC - 1) / CELL_CYC;
  localparam int PW = $clog2(PRE_CELLS + 1);
  localparam logic [ADDR_W-1:0] LAST_W = ADDR_W'(N_WORDS - 1);

  rsg_state_e             state_q, state_d;
  logic [PW-1:0]          pre_cnt_q;
  logic [ADDR_W-1:0]      widx_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_BITS-1:0]   stage_q;

  logic run, go, phase_a, cell_end;
  logic ser_clear, ser_load, ser_shift, ser_bit, fetch_cell, last_cell;
  logic pre_done, word_done, sector_done, do_fetch;
  logic [DATA_BITS-1:0]  enc_in;
  logic [WORD_CELLS-1:0] enc_cells;

  assign run = (state_q != ST_IDLE);
  assign go  = (state_q == ST_IDLE) && start_i;

  rsg_cell_timer #(.CELL_CYC(CELL_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .restart_i  (go),
    .phase_a_o  (phase_a),
    .cell_end_o (cell_end)
  );

  assign enc_in = (state_q == ST_PRE) ? SYNC_WORD : stage_q;

  rsg_check_enc u_enc (
    .data_i  (enc_in),
    .cells_o (enc_cells)
  );

  assign pre_done    = (state_q == ST_PRE) && cell_end && (pre_cnt_q == PW'(PRE_CELLS - 1));
  assign word_done   = cell_end && last_cell && ((state_q == ST_SYNC) || (state_q == ST_DATA));
  assign sector_done = word_done && (state_q == ST_DATA) && (widx_q == LAST_W);
  // capture next word one cell ahead of its first bit
  assign do_fetch    = cell_end && fetch_cell &&
                       ((state_q == ST_SYNC) || ((state_q == ST_DATA) && (widx_q != LAST_W)));

  assign ser_clear = go || sector_done;
  assign ser_load  = pre_done || (word_done && !sector_done);
  assign ser_shift = cell_end && !ser_load;

  rsg_serializer u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (ser_clear),
    .load_i       (ser_load),
    .shift_i      (ser_shift),
    .cells_i      (enc_cells),
    .bit_o        (ser_bit),
    .fetch_cell_o (fetch_cell),
    .last_cell_o  (last_cell)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)   state_d = ST_PRE;
      ST_PRE:  if (pre_done)  state_d = ST_SYNC;
      ST_SYNC: if (word_done) state_d = ST_DATA;
      ST_DATA: if (sector_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      pre_cnt_q <= '0;
      widx_q    <= '0;
      addr_q    <= '0;
      stage_q   <= '0;
    end else begin
      state_q <= state_d;
      if (go) begin
        pre_cnt_q <= '0;
        widx_q    <= '0;
        addr_q    <= '0;
      end else if ((state_q == ST_PRE) && cell_end && !pre_done) begin
        pre_cnt_q <= pre_cnt_q + 1'b1;
      end
      if (do_fetch) stage_q <= rd_data_i;
      if (sector_done) begin
        widx_q <= '0;
        addr_q <= '0;
      end else if (word_done) begin
        if (state_q == ST_DATA) widx_q <= widx_q + 1'b1;
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  assign rd_addr_o    = addr_q;
  assign busy_o       = run;
  assign clk_pulse_o  = run && phase_a;
  assign data_pulse_o = run && !phase_a && ser_bit;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              clk_pulse_o,
  input logic              data_pulse_o,
  input logic              busy_o
);
  assert_pulse_phases_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clk_pulse_o, data_pulse_o}));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!clk_pulse_o && !data_pulse_o));

  assert_busy_from_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_idle_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_addr_o == '0));

  assert_last_cell_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(data_pulse_o));
endmodule

bind rd_stream_gen rsg_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .rd_addr_o    (rd_addr_o),
  .clk_pulse_o  (clk_pulse_o),
  .data_pulse_o (data_pulse_o),
  .busy_o       (busy_o)
);

// File: tb/tb_rd_stream_gen.sv
module tb_rd_stream_gen;
  localparam int CELL = 4;
  localparam int PREC = 40;
  localparam int NW   = 321;
  localparam int PRE_CELLS = (PREC + CELL - 1) / CELL;
  localparam int AW = $clog2(NW + 1);
  localparam int TOTAL = PRE_CELLS + 20 + 20 * NW;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data;
  logic clk_p, data_p, busy;
  int mode = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rd_stream_gen #(.CELL_CYC(CELL), .PRE_CYC(PREC), .N_WORDS(NW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .clk_pulse_o(clk_p), .data_pulse_o(data_p), .busy_o(busy)
  );

  function automatic logic [15:0] pat(int m, int a);
    case (m)
      0: pat = 16'(a * 291) ^ 16'h5A5A;
      1: pat = 16'hFFFF;
      default: pat = (16'h0001 << (a % 4)) - 16'h0001;
    endcase
  endfunction

  always_ff @(posedge clk) rd_data <= pat(mode, int'(rd_addr));

  function automatic logic exp_cell(int m, int c);
    int k, w, b, ones, need;
    logic [15:0] d;
    if (c < PRE_CELLS) return 1'b0;
    k = c - PRE_CELLS;
    w = k / 20 - 1;
    b = k % 20;
    d = (w < 0) ? 16'h8000 : pat(m, w);
    if (b < 16) return d[b];
    ones = 0;
    for (int i = 0; i < 16; i++) ones += d[i];
    need = (4 - (ones % 4)) % 4;
    return (b - 16) < need;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic test_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0, "R7", "busy after reset", busy, 0);
    check(clk_p == 0 && data_p == 0, "R9", "pulses after reset", {clk_p, data_p}, 0);
    check(rd_addr == 0, "R5", "addr after reset", rd_addr, 0);
  endtask

  task automatic run_sector(int m, int inj);
    int pre_e = 0, sync_e = 0, dat_e = 0, chk_e = 0, ph_e = 0, addr_e = 0, busy_e = 0;
    int first = -1;
    logic e;
    mode = m;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int c = 0; c < TOTAL; c++) begin
      int k, b;
      k = c - PRE_CELLS;
      b = (k >= 0) ? k % 20 : 0;
      // cycle 0 of cell: phase A
      if (!busy) busy_e++;
      if (!(clk_p == 1 && data_p == 0)) ph_e++;
      if (k >= 0 && b == 10) begin
        int ea;
        ea = (k < 20) ? 0 : k / 20;
        if (int'(rd_addr) != ea) addr_e++;
      end else if (k < 0 && rd_addr != 0) addr_e++;
      @(negedge clk);
      if (c == inj) start = 1;
      @(negedge clk);
      start = 0;
      // cycle 2: phase B
      e = exp_cell(m, c);
      if (clk_p != 0) ph_e++;
      if (data_p != e) begin
        if (first < 0) first = c;
        if (k < 0) pre_e++;
        else if (k < 20) sync_e++;
        else if (b < 16) dat_e++;
        else chk_e++;
      end
      @(negedge clk);
      @(negedge clk);
    end
    check(pre_e == 0, "R1", $sformatf("preamble mismatches mode %0d first cell %0d", m, first), pre_e, 0);
    check(sync_e == 0, "R2", $sformatf("sync mismatches mode %0d first cell %0d", m, first), sync_e, 0);
    check(dat_e == 0, "R3", $sformatf("data mismatches mode %0d first cell %0d", m, first), dat_e, 0);
    check(chk_e == 0, "R4", $sformatf("check-cell mismatches mode %0d first cell %0d", m, first), chk_e, 0);
    check(ph_e == 0, "R6", $sformatf("phase errors mode %0d", m), ph_e, 0);
    check(addr_e == 0, "R5", $sformatf("addr errors mode %0d", m), addr_e, 0);
    check(busy_e == 0, "R7", $sformatf("busy low inside sector mode %0d", m), busy_e, 0);
    check(busy == 0, "R7", "busy after last cell", busy, 0);
    if (inj >= 0)
      check(pre_e + sync_e + dat_e + chk_e + busy_e == 0, "R8",
            "stream disturbed by start while busy", pre_e + sync_e + dat_e + chk_e + busy_e, 0);
  endtask

  task automatic test_idle;
    int bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (clk_p || data_p || busy) bad++;
    end
    check(bad == 0, "R9", "activity while idle", bad, 0);
    check(rd_addr == 0, "R5", "addr while idle", rd_addr, 0);
  endtask

  initial begin
    test_reset();
    run_sector(0, -1);
    test_idle();
    run_sector(1, PRE_CELLS + 20 * 7 + 5);
    test_idle();
    run_sector(2, -1);
    test_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule